// File: doc/BRIEF.md
# Buzzer Melody Sequencer

This block plays a fixed tune on a piezo buzzer. The tune is a constant table of 96 packed note entries that the block builds from a formula when it is elaborated. While the play input is held high, the block walks through the table. For each entry it takes the pitch field and turns it into a square-wave half-period. It takes the duration field and turns it into a count of coarse timing ticks. The square wave is driven on the buzzer pin for the whole length of the note.

Each note goes through a fixed sequence of steps. First the pitch is latched. Next the duration is latched and the beat timer is armed. The block then waits for the note length, and finally moves the note pointer on. After the last entry the pointer goes back to the first. A pitch of zero is a rest, and the buzzer stays low for that note. Dropping the play input stops the tune at once and rewinds it. The busy output is high whenever the sequencer is not idle.

Top module: `mel_player`

## Requirements
- R1: After reset, busy and buzz are 0, and the first note played once play_en rises is entry 0.
- R2: Entry i of the table packs the pitch in bits [7:3] and the duration code in bits [2:0]. The pitch is (PITCH_STRIDE*i) mod 32 and the code is i mod 8.
- R3: For a pitch p other than 0, the terminal count is tc = TC_BASE + (31-p)*TC_STEP. Buzz is low in the first wait cycle of the note and toggles every tc+1 cycles during the wait.
- R4: Duration codes 1, 2, 3, 4 and 5 give waits of 200, 500, 1000, 2000 and 4000 ticks. One tick is TICK_CYCLES clock cycles.
- R5: Duration codes 0, 6 and 7 give a wait of 200 ticks, so the tune never stalls.
- R6: A note with pitch 0 holds buzz low for its whole length.
- R7: Every note takes exactly 3 + wait cycles. These are one pitch-load cycle, one duration-load cycle, the wait, and one advance cycle. Busy is high in all of them, and buzz is low outside the wait.
- R8: After entry 95 the pointer returns to entry 0 and playback continues.
- R9: If play_en is low at a clock edge, then from the next cycle busy and buzz are 0 and the pointer is 0. A later rise of play_en restarts the tune at entry 0.
- R10: The tone divider count stays at zero while the tone is disabled, never goes above tc, and starts every tone from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| play_en | input | 1 | Level enable for playback; low stops and rewinds |
| buzz | output | 1 | Square-wave drive to the buzzer |
| busy | output | 1 | High while the sequencer is not idle |

## Verification
Take the falling clock edge on which play_en is driven high. The pitch-load step is sampled at the next falling edge. The duration-load step comes one cycle later. The wait then begins, and wait cycle k shows buzz equal to the parity of k/(tc+1). The advance cycle follows the last wait cycle. The next note begins one cycle after that.

When play_en is dropped on a falling edge, busy and buzz must be low at the next falling edge. The bench compares busy and buzz at every falling edge against this cycle count. It computes the count from the entry formula, the duration map and the period formula, and it covers the full tune, the wrap, and an abort in the middle of a note.

// File: rtl/mel_pkg.sv
package mel_pkg;

  localparam int DUR_TICK_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PITCH,
    ST_DUR,
    ST_WAIT,
    ST_NEXT
  } mel_state_e;

  // Non-linear duration map in ticks; unused codes fall back to the shortest.
  function automatic logic [DUR_TICK_W-1:0] dur_ticks(input logic [2:0] code);
    case (code)
      3'd1:    dur_ticks = 12'd200;
      3'd2:    dur_ticks = 12'd500;
      3'd3:    dur_ticks = 12'd1000;
      3'd4:    dur_ticks = 12'd2000;
      3'd5:    dur_ticks = 12'd4000;
      default: dur_ticks = 12'd200;
    endcase
  endfunction

endpackage

// File: rtl/mel_note_rom.sv
module mel_note_rom #(
  parameter int NUM_NOTES    = 96,
  parameter int PITCH_W      = 5,
  parameter int DUR_W        = 3,
  parameter int PITCH_STRIDE = 5,
  localparam int ENTRY_W     = PITCH_W + DUR_W,
  localparam int ADDR_W      = $clog2(NUM_NOTES)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [ENTRY_W-1:0] entry
);

  logic [ENTRY_W-1:0] table_q [NUM_NOTES];

  for (genvar g = 0; g < NUM_NOTES; g++) begin : g_entry
    localparam int P = (g * PITCH_STRIDE) % (1 << PITCH_W);
    localparam int C = g % (1 << DUR_W);
    assign table_q[g] = {PITCH_W'(P), DUR_W'(C)};
  end

  assign entry = table_q[addr];

endmodule

// File: rtl/mel_tone_div.sv
module mel_tone_div #(
  parameter int TC_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TC_W-1:0] tc,
  output logic [TC_W-1:0] cnt,
  output logic            tgl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (cnt >= tc) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl <= 1'b0;
    end else if (!en) begin
      tgl <= 1'b0;
    end else if (cnt == tc) begin
      tgl <= ~tgl;
    end
  end

endmodule

// File: rtl/mel_beat_timer.sv
module mel_beat_timer #(
  parameter int TICK_CYCLES = 12000,
  parameter int TARGET_W    = 12,
  localparam int PW         = $clog2(TICK_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                run,
  input  logic [TARGET_W-1:0] target,
  output logic                done
);

  logic [PW-1:0]       presc;
  logic [TARGET_W-1:0] ticks;
  logic                tick;

  assign tick = run && (presc == PW'(TICK_CYCLES - 1));
  assign done = tick && (ticks == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      ticks <= '0;
    end else if (load) begin
      presc <= '0;
      ticks <= '0;
    end else if (run) begin
      if (tick) begin
        presc <= '0;
        ticks <= ticks + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mel_player.sv
module mel_player #(
  parameter int NUM_NOTES    = 96,
  parameter int TICK_CYCLES  = 12000,
  parameter int TC_BASE      = 2000,
  parameter int TC_STEP      = 600,
  parameter int PITCH_STRIDE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic play_en,
  output logic buzz,
  output logic busy
);
  import mel_pkg::*;

  localparam int PITCH_W = 5;
  localparam int DUR_W   = 3;
  localparam int ENTRY_W = PITCH_W + DUR_W;
  localparam int PTR_W   = $clog2(NUM_NOTES);
  localparam int MAXP    = (1 << PITCH_W) - 1;
  localparam int TC_MAX  = TC_BASE + MAXP * TC_STEP;
  localparam int TC_W    = $clog2(TC_MAX + 1);

  mel_state_e             state;
  logic [PTR_W-1:0]       ptr;
  logic [ENTRY_W-1:0]     entry;
  logic [PITCH_W-1:0]     pitch_q;
  logic [DUR_TICK_W-1:0]  dur_q;
  logic [TC_W-1:0]        tc;
  logic [TC_W-1:0]        div_cnt;
  logic                   tgl;
  logic                   tone_en;
  logic                   beat_done;

  mel_note_rom #(
    .NUM_NOTES(NUM_NOTES), .PITCH_W(PITCH_W), .DUR_W(DUR_W),
    .PITCH_STRIDE(PITCH_STRIDE)
  ) u_rom (
    .addr(ptr), .entry(entry)
  );

  // Pitch to half-period terminal count: higher pitch, shorter count.
  assign tc = TC_W'(TC_BASE + (MAXP - int'(pitch_q)) * TC_STEP);

  assign tone_en = (state == ST_WAIT) && (pitch_q != '0);

  mel_tone_div #(.TC_W(TC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(tone_en), .tc(tc),
    .cnt(div_cnt), .tgl(tgl)
  );

  mel_beat_timer #(.TICK_CYCLES(TICK_CYCLES), .TARGET_W(DUR_TICK_W)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .load(state == ST_DUR), .run(state == ST_WAIT),
    .target(dur_q), .done(beat_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      pitch_q <= '0;
      dur_q   <= '0;
    end else if (!play_en) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      pitch_q <= '0;
    end else begin
      case (state)
        ST_IDLE:  state <= ST_PITCH;
        ST_PITCH: begin
          pitch_q <= entry[ENTRY_W-1:DUR_W];
          state   <= ST_DUR;
        end
        ST_DUR: begin
          dur_q <= dur_ticks(entry[DUR_W-1:0]);
          state <= ST_WAIT;
        end
        ST_WAIT: if (beat_done) state <= ST_NEXT;
        ST_NEXT: begin
          ptr   <= (ptr == PTR_W'(NUM_NOTES - 1)) ? '0 : ptr + 1'b1;
          state <= ST_PITCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign buzz = tgl & tone_en;

endmodule

// File: rtl/mel_player_chk.sv
module mel_player_chk #(
  parameter int NUM_NOTES = 96,
  parameter int PTR_W     = 7,
  parameter int PITCH_W   = 5,
  parameter int TC_W      = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                play_en,
  input logic                buzz,
  input logic                busy,
  input mel_pkg::mel_state_e state,
  input logic [PTR_W-1:0]    ptr,
  input logic [PITCH_W-1:0]  pitch_q,
  input logic                tone_en,
  input logic [TC_W-1:0]     div_cnt,
  input logic [TC_W-1:0]     tc
);
  import mel_pkg::*;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buzz);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> (!busy && ptr == '0));

  p_rest_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pitch_q == '0) |-> !buzz);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT && ptr == PTR_W'(NUM_NOTES - 1) && play_en) |=> ptr == '0);

  p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(NUM_NOTES - 1));

  p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PITCH && play_en) |=> state == ST_DUR);

  p_div_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en |-> div_cnt <= tc);

  p_div_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_en) |-> div_cnt == '0);

  p_toggle_at_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && $past(tone_en) && buzz != $past(buzz)) |-> $past(div_cnt) == $past(tc));

endmodule

bind mel_player mel_player_chk #(
  .NUM_NOTES(NUM_NOTES), .PTR_W(PTR_W), .PITCH_W(PITCH_W), .TC_W(TC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .play_en(play_en), .buzz(buzz), .busy(busy),
  .state(state), .ptr(ptr), .pitch_q(pitch_q), .tone_en(tone_en),
  .div_cnt(div_cnt), .tc(tc)
);

// File: tb/mel_player_test.sv
module mel_player_test;

  localparam int TICK  = 1;
  localparam int TCB   = 3;
  localparam int TCS   = 1;
  localparam int STRD  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic play_en = 1'b0;
  logic buzz;
  logic busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mel_player #(
    .NUM_NOTES(96), .TICK_CYCLES(TICK), .TC_BASE(TCB), .TC_STEP(TCS),
    .PITCH_STRIDE(STRD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .buzz(buzz), .busy(busy)
  );

  function automatic int exp_wait(int code);
    case (code)
      1: return 200 * TICK;
      2: return 500 * TICK;
      3: return 1000 * TICK;
      4: return 2000 * TICK;
      5: return 4000 * TICK;
      default: return 200 * TICK;   // R5 fallback
    endcase
  endfunction

  task automatic check1(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7: one note, sampled every cycle at the falling edge
  task automatic play_note(int i);
    int p = (STRD * i) % 32;
    int code = i % 8;
    int w = exp_wait(code);
    int tc = TCB + (31 - p) * TCS;
    bit bad = 0;
    int bc = 0, ab = 0, eb = 0, ay = 0;
    string tag;
    for (int c = 0; c < w + 3; c++) begin
      int exb;
      @(negedge clk);
      exb = (c >= 2 && c < w + 2 && p != 0) ? (((c - 2) / (tc + 1)) % 2) : 0;
      if (!bad && (buzz !== exb[0] || busy !== 1'b1)) begin
        bad = 1; bc = c; ab = buzz; eb = exb; ay = busy;
      end
    end
    if (p == 0) tag = "R6";
    else if (code == 0 || code > 5) tag = "R5";
    else tag = "R3/R4";
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s R7 note %0d cycle %0d buzz actual=%0d expected=%0d busy actual=%0d expected=1",
               tag, i, bc, ab, eb, ay);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 busy", busy === 1'b0, busy, 0);
    check1("R1 buzz", buzz === 1'b0, buzz, 0);
    rst_n = 1'b1;
    // R9: play low keeps the block idle and silent
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 19) check1("R9 idle busy", busy === 1'b0, busy, 0);
    end
    play_en = 1'b1;
    for (int i = 0; i < 96; i++) play_note(i);
    // R8: wrap back to entry 0
    play_note(0);
    play_note(1);
    // note 2: pitch 10, tc 24, buzz high in wait cycles 25..49
    repeat (30) @(negedge clk);
    check1("R3 mid-note buzz", buzz === 1'b1, buzz, 1);
    play_en = 1'b0;
    @(negedge clk);
    check1("R9 abort busy", busy === 1'b0, busy, 0);
    check1("R9 abort buzz", buzz === 1'b0, buzz, 0);
    repeat (5) @(negedge clk);
    play_en = 1'b1;
    play_note(0);   // R9 restart from entry 0
    play_note(1);
    play_note(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule